// File: doc/BRIEF.md
# Serial Programming Channel Pin Ownership and Status Control

This block decides when a group of shared port pins stops acting as general-purpose I/O and is handed to a serial test and programming channel. Three sources can grant the pins, and any one of them is enough: a non-volatile configuration bit, a run-time enable bit that the processor writes, and a select term from the programmable logic. The device reset acts differently on these sources. It clears the run-time bit and at once removes the ownership that bit grants. It leaves ownership from the non-volatile bit or the logic term alone.

The four basic channel pins are mode-select, serial clock, serial data in and serial data out. After the pins are taken over, all four start as inputs. The serial data out pin becomes an output only when the channel's enter command arrives. The same command also brings two extension pins into use. One is a ready/busy status pin. The other is a sticky, active-low error pin that shows failures of the flash engine, so that a programmer can see them without shifting status out serially. An exit command returns the two extension pins to general I/O.

The TAP controller, the instruction decoder and the flash engine sit outside this block. They appear here as command strobes and as status inputs. The outputs are, for each port pin, an ownership flag, an output enable and a drive value, which the port multiplexer uses.

Top module: `jtag_pin_ctl`

## Requirements
- R1: Port bits 0 (mode-select), 1 (serial clock), 5 (serial data in) and 6 (serial data out) are owned by the channel when the non-volatile bit, the logic select term or the run-time enable bit is 1. When none of the three is 1, no port bit is owned and every `pin_own` bit is 0.
- R2: The run-time enable is bit 0 of the register at bus offset C7h. A write sets the bit to `bus_wdata[0]`. A read at C7h returns the bit in bit 0, with all other bits 0. A write at any other offset has no effect.
- R3: While `dev_rst_n` is low, ownership granted only by the run-time bit is removed in the same cycle, and the run-time bit is cleared. It reads back 0 after the reset.
- R4: While the non-volatile bit or the logic term holds, a device reset changes neither ownership nor the serial-out enable nor the extension-pin state.
- R5: Once the pins are owned, bit 6 stays an input (`pin_oe[6]`=0) until an enter command. From the cycle after the command, bit 6 is an output that drives `tap_sout`.
- R6: Bits 3 (status) and 4 (error) are owned and driven only after an enter command. An exit command returns them to general I/O. When enter and exit arrive in the same cycle, exit wins.
- R7: The status pin (bit 3) drives 1 when `flash_busy` is 0 and drives 0 when `flash_busy` is 1, in the same cycle.
- R8: After a `flash_err` pulse, the error pin (bit 4) drives 0 from the next cycle onward. It stays 0 until a clear command or a device reset, and it drives 1 whenever no error is latched. An error and a clear in the same cycle leave the error latched.
- R9: When ownership drops, the serial-out enable and the extension state are cleared. A later grant starts again with bit 6 as an input and bits 3 and 4 free.
- R10: Enter, exit and clear commands that arrive while the pins are not owned have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| dev_rst_n | input | 1 | Device reset level, active low |
| nv_cfg_en | input | 1 | Non-volatile pin-dedication bit |
| logic_sel_en | input | 1 | Programmable-logic select term |
| bus_cs | input | 1 | Register bus chip select |
| bus_we | input | 1 | Register bus write strobe |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data |
| cmd_enter | input | 1 | Decoded enter-configuration strobe |
| cmd_exit | input | 1 | Decoded exit-configuration strobe |
| cmd_clear | input | 1 | Decoded clear-error strobe |
| flash_busy | input | 1 | Flash engine busy |
| flash_err | input | 1 | Flash engine error pulse |
| tap_sout | input | 1 | Serial data from the TAP |
| chan_active | output | 1 | Channel currently owns its pins |
| pin_own | output | PORT_W | Per-pin channel ownership |
| pin_oe | output | PORT_W | Per-pin output enable under channel ownership |
| pin_dout | output | PORT_W | Per-pin drive value |

## Verification
The bench targets the cycle in which a device reset drops the register-granted pins. A design that waited for the register to clear would still hold the pins for one cycle. It resets the device while the logic term holds the pins, where a design that reset the session state would turn bit 6 back into an input in the middle of a transfer. It sends an error and a clear in the same cycle, where a design with the wrong priority would lose the error. It also sends enter and exit in the same cycle, and sends commands while the pins are free, where a design that accepted them would bring up a live output as soon as the pins are next granted.

// File: rtl/jpc_pkg.sv
package jpc_pkg;
   typedef enum logic [2:0] {
      ROLE_GPIO = 3'd0,
      ROLE_MODE = 3'd1,
      ROLE_SCLK = 3'd2,
      ROLE_SIN  = 3'd3,
      ROLE_SOUT = 3'd4,
      ROLE_STAT = 3'd5,
      ROLE_ERR  = 3'd6
   } pin_role_e;

   typedef struct packed {
      logic chan_on;
      logic sout_en;
      logic ext_en;
      logic err_set;
   } chan_state_t;
endpackage

// File: rtl/jpc_enable_reg.sv
module jpc_enable_reg #(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned ENA_OFFSET = 'hC7,
   parameter int unsigned ENA_BIT    = 0
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              dev_rst_n,
   input  logic              bus_cs,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              ena_q
);
   localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(ENA_OFFSET);

   logic hit;
   assign hit = bus_cs && (bus_addr == OFFS);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)          ena_q <= 1'b0;
      else if (!dev_rst_n) ena_q <= 1'b0;
      else if (hit && bus_we) ena_q <= bus_wdata[ENA_BIT];
   end

   always_comb begin
      bus_rdata = '0;
      if (hit) bus_rdata[ENA_BIT] = ena_q;
   end
endmodule

// File: rtl/jpc_session.sv
module jpc_session (
   input  logic clk,
   input  logic por_n,
   input  logic chan_on,
   input  logic cmd_enter,
   input  logic cmd_exit,
   output logic sout_en_q,
   output logic ext_en_q
);
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         sout_en_q <= 1'b0;
         ext_en_q  <= 1'b0;
      end else if (!chan_on) begin
         sout_en_q <= 1'b0;
         ext_en_q  <= 1'b0;
      end else begin
         if (cmd_enter) sout_en_q <= 1'b1;
         if (cmd_exit)       ext_en_q <= 1'b0;
         else if (cmd_enter) ext_en_q <= 1'b1;
      end
   end
endmodule

// File: rtl/jpc_err_latch.sv
module jpc_err_latch (
   input  logic clk,
   input  logic por_n,
   input  logic dev_rst_n,
   input  logic chan_on,
   input  logic flash_err,
   input  logic cmd_clear,
   output logic err_q
);
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                    err_q <= 1'b0;
      else if (!dev_rst_n)           err_q <= 1'b0;
      else if (flash_err)            err_q <= 1'b1;
      else if (cmd_clear && chan_on) err_q <= 1'b0;
   end
endmodule

// File: rtl/jpc_pin_map.sv
module jpc_pin_map
   import jpc_pkg::*;
#(
   parameter int unsigned PORT_W   = 8,
   parameter int unsigned PIN_MODE = 0,
   parameter int unsigned PIN_SCLK = 1,
   parameter int unsigned PIN_STAT = 3,
   parameter int unsigned PIN_ERR  = 4,
   parameter int unsigned PIN_SIN  = 5,
   parameter int unsigned PIN_SOUT = 6
) (
   input  chan_state_t       st,
   input  logic              flash_busy,
   input  logic              tap_sout,
   output logic [PORT_W-1:0] pin_own,
   output logic [PORT_W-1:0] pin_oe,
   output logic [PORT_W-1:0] pin_dout
);
   function automatic pin_role_e role_of(int unsigned idx);
      if (idx == PIN_MODE) return ROLE_MODE;
      if (idx == PIN_SCLK) return ROLE_SCLK;
      if (idx == PIN_SIN)  return ROLE_SIN;
      if (idx == PIN_SOUT) return ROLE_SOUT;
      if (idx == PIN_STAT) return ROLE_STAT;
      if (idx == PIN_ERR)  return ROLE_ERR;
      return ROLE_GPIO;
   endfunction

   for (genvar i = 0; i < PORT_W; i++) begin : g_pin
      localparam pin_role_e ROLE = role_of(i);
      if (ROLE == ROLE_GPIO) begin : g_gpio
         assign pin_own[i]  = 1'b0;
         assign pin_oe[i]   = 1'b0;
         assign pin_dout[i] = 1'b0;
      end else if (ROLE == ROLE_SOUT) begin : g_sout
         assign pin_own[i]  = st.chan_on;
         assign pin_oe[i]   = st.chan_on & st.sout_en;
         assign pin_dout[i] = tap_sout;
      end else if (ROLE == ROLE_STAT) begin : g_stat
         assign pin_own[i]  = st.chan_on & st.ext_en;
         assign pin_oe[i]   = st.chan_on & st.ext_en;
         assign pin_dout[i] = ~flash_busy;
      end else if (ROLE == ROLE_ERR) begin : g_err
         assign pin_own[i]  = st.chan_on & st.ext_en;
         assign pin_oe[i]   = st.chan_on & st.ext_en;
         assign pin_dout[i] = ~st.err_set;
      end else begin : g_input
         assign pin_own[i]  = st.chan_on;
         assign pin_oe[i]   = 1'b0;
         assign pin_dout[i] = 1'b0;
      end
   end
endmodule

// File: rtl/jtag_pin_ctl.sv
module jtag_pin_ctl
   import jpc_pkg::*;
#(
   parameter int unsigned PORT_W     = 8,
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned ENA_OFFSET = 'hC7,
   parameter int unsigned ENA_BIT    = 0,
   parameter int unsigned PIN_MODE   = 0,
   parameter int unsigned PIN_SCLK   = 1,
   parameter int unsigned PIN_STAT   = 3,
   parameter int unsigned PIN_ERR    = 4,
   parameter int unsigned PIN_SIN    = 5,
   parameter int unsigned PIN_SOUT   = 6
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              dev_rst_n,
   input  logic              nv_cfg_en,
   input  logic              logic_sel_en,
   input  logic              bus_cs,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              cmd_enter,
   input  logic              cmd_exit,
   input  logic              cmd_clear,
   input  logic              flash_busy,
   input  logic              flash_err,
   input  logic              tap_sout,
   output logic              chan_active,
   output logic [PORT_W-1:0] pin_own,
   output logic [PORT_W-1:0] pin_oe,
   output logic [PORT_W-1:0] pin_dout
);
   localparam int unsigned PIN_MAX = PORT_W - 1;

   if (PIN_MODE > PIN_MAX || PIN_SCLK > PIN_MAX || PIN_SIN > PIN_MAX ||
       PIN_SOUT > PIN_MAX || PIN_STAT > PIN_MAX || PIN_ERR > PIN_MAX) begin : g_bad_pin
      $error("pin index beyond port width");
   end
   if (ENA_BIT >= DATA_W) begin : g_bad_bit
      $error("enable bit beyond data width");
   end
   if (ENA_OFFSET >= (1 << ADDR_W)) begin : g_bad_offs
      $error("enable offset beyond address width");
   end

   logic        ena_q;
   logic        sout_en_q;
   logic        ext_en_q;
   logic        err_q;
   logic        chan_on;
   chan_state_t st;

   jpc_enable_reg #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .ENA_OFFSET(ENA_OFFSET), .ENA_BIT(ENA_BIT)
   ) u_ena (
      .clk(clk), .por_n(por_n), .dev_rst_n(dev_rst_n),
      .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ena_q(ena_q)
   );

   // The register grant is gated by the reset level; the other two are not.
   assign chan_on     = nv_cfg_en | logic_sel_en | (ena_q & dev_rst_n);
   assign chan_active = chan_on;

   jpc_session u_sess (
      .clk(clk), .por_n(por_n), .chan_on(chan_on),
      .cmd_enter(cmd_enter), .cmd_exit(cmd_exit),
      .sout_en_q(sout_en_q), .ext_en_q(ext_en_q)
   );

   jpc_err_latch u_err (
      .clk(clk), .por_n(por_n), .dev_rst_n(dev_rst_n), .chan_on(chan_on),
      .flash_err(flash_err), .cmd_clear(cmd_clear), .err_q(err_q)
   );

   always_comb begin
      st.chan_on = chan_on;
      st.sout_en = sout_en_q;
      st.ext_en  = ext_en_q;
      st.err_set = err_q;
   end

   jpc_pin_map #(
      .PORT_W(PORT_W), .PIN_MODE(PIN_MODE), .PIN_SCLK(PIN_SCLK),
      .PIN_STAT(PIN_STAT), .PIN_ERR(PIN_ERR), .PIN_SIN(PIN_SIN), .PIN_SOUT(PIN_SOUT)
   ) u_map (
      .st(st), .flash_busy(flash_busy), .tap_sout(tap_sout),
      .pin_own(pin_own), .pin_oe(pin_oe), .pin_dout(pin_dout)
   );
endmodule

// File: rtl/jtag_pin_ctl_chk.sv
module jtag_pin_ctl_chk #(
   parameter int unsigned PORT_W   = 8,
   parameter int unsigned PIN_STAT = 3,
   parameter int unsigned PIN_ERR  = 4,
   parameter int unsigned PIN_SOUT = 6
) (
   input logic              clk,
   input logic              por_n,
   input logic              dev_rst_n,
   input logic              nv_cfg_en,
   input logic              logic_sel_en,
   input logic              cmd_exit,
   input logic              cmd_clear,
   input logic              flash_busy,
   input logic              chan_active,
   input logic [PORT_W-1:0] pin_own,
   input logic [PORT_W-1:0] pin_oe,
   input logic [PORT_W-1:0] pin_dout
);
   assert_no_grant_R1: assert property (@(posedge clk) disable iff (!por_n)
      (!nv_cfg_en && !logic_sel_en && !dev_rst_n) |-> (pin_own == '0));

   assert_sout_starts_input_R5: assert property (@(posedge clk) disable iff (!por_n)
      $rose(pin_own[PIN_SOUT]) |-> !pin_oe[PIN_SOUT]);

   assert_exit_frees_ext_R6: assert property (@(posedge clk) disable iff (!por_n)
      cmd_exit |=> !pin_own[PIN_STAT] && !pin_own[PIN_ERR]);

   assert_status_follows_R7: assert property (@(posedge clk) disable iff (!por_n)
      pin_own[PIN_STAT] |-> (pin_dout[PIN_STAT] != flash_busy));

   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!por_n)
      (!pin_dout[PIN_ERR] && dev_rst_n && !cmd_clear) |=> !pin_dout[PIN_ERR]);

   assert_drop_clears_R9: assert property (@(posedge clk) disable iff (!por_n)
      !chan_active |=> !pin_oe[PIN_SOUT] && !pin_own[PIN_STAT]);
endmodule

bind jtag_pin_ctl jtag_pin_ctl_chk #(
   .PORT_W(PORT_W), .PIN_STAT(PIN_STAT), .PIN_ERR(PIN_ERR), .PIN_SOUT(PIN_SOUT)
) u_chk (
   .clk(clk), .por_n(por_n), .dev_rst_n(dev_rst_n), .nv_cfg_en(nv_cfg_en),
   .logic_sel_en(logic_sel_en), .cmd_exit(cmd_exit), .cmd_clear(cmd_clear),
   .flash_busy(flash_busy), .chan_active(chan_active), .pin_own(pin_own),
   .pin_oe(pin_oe), .pin_dout(pin_dout)
);

// File: tb/test_jtag_pin_ctl.sv
`timescale 1ns/1ps
module test_jtag_pin_ctl;
   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       dev_rst_n = 1'b1;
   logic       nv_cfg_en = 1'b0, logic_sel_en = 1'b0;
   logic       bus_cs = 1'b0, bus_we = 1'b0;
   logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       cmd_enter = 1'b0, cmd_exit = 1'b0, cmd_clear = 1'b0;
   logic       flash_busy = 1'b0, flash_err = 1'b0, tap_sout = 1'b0;
   logic       chan_active;
   logic [7:0] pin_own, pin_oe, pin_dout;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   jtag_pin_ctl i_jtag_pin_ctl (
      .clk(clk), .por_n(por_n), .dev_rst_n(dev_rst_n), .nv_cfg_en(nv_cfg_en),
      .logic_sel_en(logic_sel_en), .bus_cs(bus_cs), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cmd_enter(cmd_enter), .cmd_exit(cmd_exit), .cmd_clear(cmd_clear),
      .flash_busy(flash_busy), .flash_err(flash_err), .tap_sout(tap_sout),
      .chan_active(chan_active), .pin_own(pin_own), .pin_oe(pin_oe), .pin_dout(pin_dout)
   );

   // Behavioural reference state, built from the requirements.
   bit m_ena, m_sout, m_ext, m_err;

   function automatic bit m_chan();
      return nv_cfg_en || logic_sel_en || (m_ena && dev_rst_n);
   endfunction

   always @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         m_ena <= 0; m_sout <= 0; m_ext <= 0; m_err <= 0;
      end else begin
         bit ch;
         ch = m_chan();
         if (!dev_rst_n) m_ena <= 0;
         else if (bus_cs && bus_we && bus_addr == 8'hC7) m_ena <= bus_wdata[0];
         if (!ch) begin m_sout <= 0; m_ext <= 0; end
         else begin
            if (cmd_enter) m_sout <= 1;
            if (cmd_exit) m_ext <= 0; else if (cmd_enter) m_ext <= 1;
         end
         if (!dev_rst_n) m_err <= 0;
         else if (flash_err) m_err <= 1;
         else if (cmd_clear && ch) m_err <= 0;
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Compare every cycle against the model, away from the active edge.
   always @(negedge clk) begin
      if (por_n && !done) begin
         logic [7:0] e_own, e_oe, e_dout, e_rd;
         e_own  = m_chan() ? (8'h63 | (m_ext ? 8'h18 : 8'h00)) : 8'h00;
         e_oe   = m_chan() ? ((m_sout ? 8'h40 : 8'h00) | (m_ext ? 8'h18 : 8'h00)) : 8'h00;
         e_dout = {1'b0, tap_sout, 1'b0, ~m_err, ~flash_busy, 3'b000};
         e_rd   = (bus_cs && bus_addr == 8'hC7) ? {7'd0, m_ena} : 8'h00;
         chk("R1 pin_own model", pin_own, e_own);
         chk("R5 pin_oe model", pin_oe, e_oe);
         chk("R8 pin_dout model", pin_dout, e_dout);
         chk("R2 bus_rdata model", bus_rdata, e_rd);
      end
   end

   task automatic tick(int n = 1);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic settle();
      @(negedge clk); #0.5;
   endtask

   task automatic bus_write(logic [7:0] a, logic [7:0] d);
      bus_cs = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
      tick();
      bus_cs = 0; bus_we = 0;
   endtask

   task automatic pulse_enter(); cmd_enter = 1; tick(); cmd_enter = 0; endtask

   initial begin
      tick(3);
      settle();
      chk("R1 reset no ownership", pin_own, 8'h00);
      chk("R5 reset no output", pin_oe, 8'h00);
      por_n = 1;
      tick();

      // R2 register grant and readback
      bus_write(8'hC7, 8'h01);
      bus_cs = 1; bus_addr = 8'hC7;
      settle();
      chk("R2 readback bit0", bus_rdata, 8'h01);
      chk("R1 register grant", pin_own, 8'h63);
      chk("R5 sout input before enter", pin_oe[6], 1'b0);
      tick(); bus_cs = 0;

      // R5/R6 enter command
      tap_sout = 1;
      pulse_enter();
      settle();
      chk("R6 extension owned", pin_own, 8'h7B);
      chk("R5 sout output", pin_oe[6], 1'b1);
      chk("R5 sout drives tap", pin_dout[6], 1'b1);
      tick(); tap_sout = 0;

      // R7 status pin
      flash_busy = 1; settle();
      chk("R7 busy low", pin_dout[3], 1'b0);
      tick(); flash_busy = 0; settle();
      chk("R7 ready high", pin_dout[3], 1'b1);
      tick();

      // R8 sticky error and priority
      flash_err = 1; tick(); flash_err = 0; tick(3);
      settle();
      chk("R8 error held", pin_dout[4], 1'b0);
      tick();
      flash_err = 1; cmd_clear = 1; tick(); flash_err = 0; cmd_clear = 0;
      settle();
      chk("R8 set beats clear", pin_dout[4], 1'b0);
      tick();
      cmd_clear = 1; tick(); cmd_clear = 0; settle();
      chk("R8 clear releases", pin_dout[4], 1'b1);
      tick();

      // R6 enter and exit together
      cmd_enter = 1; cmd_exit = 1; tick(); cmd_enter = 0; cmd_exit = 0;
      settle();
      chk("R6 exit wins", pin_own[4:3], 2'b00);
      tick();

      // R2 wrong offset ignored
      bus_write(8'hC6, 8'h00);
      settle();
      chk("R2 other offset ignored", pin_own, 8'h63);
      tick();

      // R3 device reset drops register grant at once
      dev_rst_n = 0; #0.5;
      chk("R3 same-cycle drop", pin_own, 8'h00);
      tick(2); dev_rst_n = 1;
      bus_cs = 1; bus_addr = 8'hC7; settle();
      chk("R3 register cleared", bus_rdata, 8'h00);
      chk("R3 stays released", pin_own, 8'h00);
      tick(); bus_cs = 0;

      // R10 commands while free have no effect
      cmd_enter = 1; tick(); cmd_enter = 0;
      logic_sel_en = 1; settle();
      chk("R10 enter ignored while free", pin_oe, 8'h00);
      chk("R1 logic term grant", pin_own, 8'h63);
      tick();

      // R4 reset does not disturb a logic-term grant
      pulse_enter();
      flash_err = 1; tick(); flash_err = 0;
      dev_rst_n = 0; tick(2); dev_rst_n = 1; settle();
      chk("R4 ownership kept", pin_own, 8'h7B);
      chk("R4 sout enable kept", pin_oe[6], 1'b1);
      chk("R8 reset clears error", pin_dout[4], 1'b1);
      tick();

      // R9 hand over to nv bit, then drop and regrant
      nv_cfg_en = 1; logic_sel_en = 0; tick();
      dev_rst_n = 0; tick(); dev_rst_n = 1; settle();
      chk("R4 nv grant survives reset", pin_own, 8'h7B);
      tick();
      nv_cfg_en = 0; tick();
      nv_cfg_en = 1; settle();
      chk("R9 regrant sout input", pin_oe[6], 1'b0);
      chk("R9 regrant ext free", pin_own, 8'h63);
      tick(2);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(4 * 20000);
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule